// File: doc/BRIEF.md
# Receiver Error and Interrupt Controller

This block sits behind the front end of a digital audio receiver. It takes a set of per-cycle event flags and turns them into two interrupt pins, a status word and the gating of the audio paths. The event flags are loss of lock, parity error, non-PCM stream detection, audio flag, validity, Q-subcode update, channel-status change and data detection. The audio gating either forces samples to zero, repeats the last good sample, or lets samples through. The recovered serial data line is also forced low while lock is lost. The block issues a one-cycle pulse that tells the metadata stores (channel status, user bits, burst preamble words) to return to their initial values.

Two control modes are supported. In fixed (parallel) mode, each pin has a hard-wired group of events, and the release hold on the first pin has a fixed length. In programmable (serial) mode, each pin has a mask. The hold length comes from a 2-bit field. The last three status bits latch until software reads the status word, and they feed the pins while they are latched. The first interrupt pin stays high for a number of sample periods after its causes go away. The second pin follows its causes with no delay.

Top module: `rxerr_irq_ctrl`

## Requirements
- R1: With `serial_mode`=0, `int0` is driven by events 0 (unlock) and 1 (parity), and `int1` is the OR of events 2 (non-PCM) and 3 (audio). Both masks and `hold_sel` have no effect in this mode.
- R2: `int0` rises in the same cycle as any contributing source. After all sources clear, it stays high until N `fs_tick` edges have been counted. In fixed mode N is 1024.
- R3: With `serial_mode`=1, N is selected by `hold_sel`: 00 gives 512, 01 gives 1024, 10 gives 2048 and 11 gives 4096.
- R4: With `serial_mode`=1, `int1` is the OR of status bits not masked by `mask_int1`. It drops in the same cycle its sources clear.
- R5: A 1 in bit i of `mask_int0` or `mask_int1` removes status bit i from that pin only. Status bit i still reports the event.
- R6: Status bits 0..4 (unlock, parity, non-PCM, audio, validity) equal `evt_in[4:0]` in the same cycle, with no latching.
- R7: Status bits 5..7 (Q-subcode, channel status, data detect) set on the edge after their event. They stay 1 until a cycle with `stat_rd`=1, and they clear on the edge that ends that cycle.
- R8: An event in the same cycle as `stat_rd` wins, so that sticky bit stays 1.
- R9: On each edge with `fs_tick`=1, `sample_out` loads 0 if unlock is set. If parity is set without unlock, it keeps its value. Otherwise it loads `sample_in`. Without `fs_tick`, it keeps its value.
- R10: `rdata_out` is 0 while unlock is set and equals `rdata_in` otherwise, in the same cycle.
- R11: `meta_clr` is high for exactly one cycle, starting on the edge after unlock rises.
- R12: `serial_mode` selects between the two behaviours above. Every pin group and hold length follows the current mode with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 1 selects programmable mode, 0 selects fixed mode |
| evt_in | input | 8 | Event flags; bit 0 unlock, 1 parity, 2 non-PCM, 3 audio, 4 validity, 5 Q-subcode, 6 channel status, 7 data detect |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| mask_int0 | input | 8 | Per-event mask for int0, 1 masks |
| mask_int1 | input | 8 | Per-event mask for int1, 1 masks |
| hold_sel | input | 2 | int0 hold length select in programmable mode |
| stat_rd | input | 1 | Status word read strobe |
| sample_in | input | SAMPLE_W | Decoded audio sample |
| rdata_in | input | 1 | Recovered serial data |
| int0 | output | 1 | Interrupt pin with release hold |
| int1 | output | 1 | Interrupt pin without hold |
| status | output | 8 | Status word, same bit order as evt_in |
| sample_out | output | SAMPLE_W | Gated audio sample |
| rdata_out | output | 1 | Gated recovered data |
| meta_clr | output | 1 | One-cycle clear pulse for metadata stores |

## Verification
The pins, status bits 0..4 and `rdata_out` are combinational, so the bench drives inputs on the falling edge and samples 1 ns later in the same cycle. Sticky bits, `sample_out` and `meta_clr` change on the first rising edge after the stimulus, so they are checked on the following falling edge. The `int0` release is checked in two places. It must still be high after N-1 counted edges, measured from the first rising edge after the sources drop. It must be low after the Nth edge. The restart case counts again from the reassertion.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NUM_EVT      = 8;
  localparam int EV_UNLOCK    = 0;
  localparam int EV_PARITY    = 1;
  localparam int EV_NONPCM    = 2;
  localparam int EV_AUDIO     = 3;
  localparam int EV_VALID     = 4;
  localparam int FIRST_STICKY = 5;

  typedef enum logic [1:0] {
    HOLD_X1 = 2'b00,
    HOLD_X2 = 2'b01,
    HOLD_X4 = 2'b10,
    HOLD_X8 = 2'b11
  } hold_sel_e;

  typedef enum logic [1:0] {
    GATE_PASS   = 2'b00,
    GATE_REPEAT = 2'b01,
    GATE_ZERO   = 2'b10
  } gate_e;
endpackage

// File: rtl/rxerr_hold_timer.sv
module rxerr_hold_timer
  import rxerr_pkg::*;
#(
  parameter int BASE_HOLD = 512
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src,
  input  logic      tick,
  input  hold_sel_e sel,
  output logic      irq
);
  localparam int CW = $clog2(BASE_HOLD * 8);

  logic          hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_m1;

  always_comb begin
    case (sel)
      HOLD_X1: lim_m1 = CW'(BASE_HOLD - 1);
      HOLD_X2: lim_m1 = CW'(BASE_HOLD * 2 - 1);
      HOLD_X4: lim_m1 = CW'(BASE_HOLD * 4 - 1);
      default: lim_m1 = CW'(BASE_HOLD * 8 - 1);
    endcase
  end

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (src) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q && tick) begin
      if (cnt_q >= lim_m1) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign irq = src | hold_q;

  // R2
  src_arms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src |=> hold_q);

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(tick) && !$past(src)));
endmodule

// File: rtl/rxerr_status_regs.sv
module rxerr_status_regs
  import rxerr_pkg::*;
#(
  parameter int N_EVT   = NUM_EVT,
  parameter int N_LIVE  = FIRST_STICKY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             rd,
  output logic [N_EVT-1:0] status
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    if (i < N_LIVE) begin : g_live
      assign status[i] = evt[i];
    end else begin : g_sticky
      logic flag_q, flag_d;

      always_comb flag_d = evt[i] | (flag_q & ~rd);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end

      assign status[i] = flag_q;

      // R7
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> status[i]);

      // R7
      sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[i]) |-> $past(rd));
    end
  end
endmodule

// File: rtl/rxerr_sample_gate.sv
module rxerr_sample_gate
  import rxerr_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                unlock,
  input  logic                parity,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                rdata_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                rdata_out,
  output logic                meta_clr
);
  gate_e               gate;
  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic                unl_q, clr_q, clr_d;

  always_comb begin
    if (unlock)      gate = GATE_ZERO;
    else if (parity) gate = GATE_REPEAT;
    else             gate = GATE_PASS;
  end

  always_comb begin
    smp_d = smp_q;
    if (tick) begin
      case (gate)
        GATE_ZERO:   smp_d = '0;
        GATE_REPEAT: smp_d = smp_q;
        default:     smp_d = sample_in;
      endcase
    end
    clr_d = unlock & ~unl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      unl_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      unl_q <= unlock;
      clr_q <= clr_d;
    end
  end

  assign sample_out = smp_q;
  assign rdata_out  = rdata_in & ~unlock;
  assign meta_clr   = clr_q;

  // R9
  zero_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && unlock) |=> (sample_out == '0));

  // R9
  repeat_on_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && parity && !unlock) |=> $stable(sample_out));

  // R11
  meta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meta_clr |=> !meta_clr);
endmodule

// File: rtl/rxerr_irq_ctrl.sv
module rxerr_irq_ctrl
  import rxerr_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int BASE_HOLD = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                serial_mode,
  input  logic [7:0]          evt_in,
  input  logic                fs_tick,
  input  logic [7:0]          mask_int0,
  input  logic [7:0]          mask_int1,
  input  logic [1:0]          hold_sel,
  input  logic                stat_rd,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                rdata_in,
  output logic                int0,
  output logic                int1,
  output logic [7:0]          status,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                rdata_out,
  output logic                meta_clr
);
  logic      rst_s1_q, rst_s2_q;
  logic      src0, src1;
  hold_sel_e sel_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  rxerr_status_regs #(
    .N_EVT  (NUM_EVT),
    .N_LIVE (FIRST_STICKY)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .evt    (evt_in),
    .rd     (stat_rd),
    .status (status)
  );

  always_comb begin
    if (serial_mode) begin
      src0    = |(status & ~mask_int0);
      src1    = |(status & ~mask_int1);
      sel_eff = hold_sel_e'(hold_sel);
    end else begin
      src0    = evt_in[EV_UNLOCK] | evt_in[EV_PARITY];
      src1    = evt_in[EV_NONPCM] | evt_in[EV_AUDIO];
      sel_eff = HOLD_X2;
    end
  end

  rxerr_hold_timer #(
    .BASE_HOLD (BASE_HOLD)
  ) u_hold (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .src   (src0),
    .tick  (fs_tick),
    .sel   (sel_eff),
    .irq   (int0)
  );

  assign int1 = src1;

  rxerr_sample_gate #(
    .SAMPLE_W (SAMPLE_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .tick       (fs_tick),
    .unlock     (evt_in[EV_UNLOCK]),
    .parity     (evt_in[EV_PARITY]),
    .sample_in  (sample_in),
    .rdata_in   (rdata_in),
    .sample_out (sample_out),
    .rdata_out  (rdata_out),
    .meta_clr   (meta_clr)
  );

  // R6
  live_status_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    status[FIRST_STICKY-1:0] == evt_in[FIRST_STICKY-1:0]);

  // R1
  fixed_int0_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (!serial_mode && (evt_in[EV_UNLOCK] || evt_in[EV_PARITY])) |-> int0);
endmodule

// File: tb/rxerr_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rxerr_irq_ctrl_bench;
  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          serial_mode;
  logic [7:0]    evt_in;
  logic          fs_tick;
  logic [7:0]    mask_int0, mask_int1;
  logic [1:0]    hold_sel;
  logic          stat_rd;
  logic [SW-1:0] sample_in;
  logic          rdata_in;
  logic          int0, int1;
  logic [7:0]    status;
  logic [SW-1:0] sample_out;
  logic          rdata_out, meta_clr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rxerr_irq_ctrl #(.SAMPLE_W(SW), .BASE_HOLD(512)) u_rxerr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .evt_in(evt_in),
    .fs_tick(fs_tick), .mask_int0(mask_int0), .mask_int1(mask_int1),
    .hold_sel(hold_sel), .stat_rd(stat_rd), .sample_in(sample_in),
    .rdata_in(rdata_in), .int0(int0), .int1(int1), .status(status),
    .sample_out(sample_out), .rdata_out(rdata_out), .meta_clr(meta_clr)
  );

  // {serial, evt[4:0], mask_int1, rdata_in, exp int1, exp rdata_out}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 5'b00001, 8'hFF, 1'b1, 1'b0, 1'b0},
    {1'b0, 5'b00100, 8'hFF, 1'b1, 1'b1, 1'b1},
    {1'b0, 5'b01000, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b0, 5'b10000, 8'h00, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'b10000, 8'h00, 1'b1, 1'b1, 1'b1},
    {1'b1, 5'b10000, 8'h10, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'b00011, 8'h03, 1'b1, 1'b0, 1'b0},
    {1'b1, 5'b00000, 8'h00, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Arms int0 with one event cycle, drops it, then verifies release after n edges.
  task automatic hold_run(input string req, input logic [7:0] ev, input int n);
    @(negedge clk); evt_in = ev;
    #1 chk({req, " int0 rises at once"}, 32'(int0), 32'd1);
    @(negedge clk); evt_in = 8'h00;
    repeat (n - 1) @(posedge clk);
    #1 chk({req, " int0 held before limit"}, 32'(int0), 32'd1);
    @(posedge clk);
    #1 chk({req, " int0 released at limit"}, 32'(int0), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; serial_mode = 1'b0; evt_in = '0; fs_tick = 1'b0;
    mask_int0 = 8'hFF; mask_int1 = '0; hold_sel = 2'b00; stat_rd = 1'b0;
    sample_in = '0; rdata_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("reset int0", 32'(int0), 32'd0);
    chk("reset int1", 32'(int1), 32'd0);
    chk("reset status", 32'(status), 32'd0);
    chk("reset sample_out", 32'(sample_out), 32'd0);
    chk("reset meta_clr", 32'(meta_clr), 32'd0);

    // Table: combinational pin, status and data-gate behaviour (R1 R4 R5 R6 R10 R12)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      serial_mode = VEC[i][16];
      evt_in      = {3'b000, VEC[i][15:11]};
      mask_int1   = VEC[i][10:3];
      rdata_in    = VEC[i][2];
      #1;
      chk($sformatf("R4/R1/R12 int1 row %0d", i), 32'(int1), 32'(VEC[i][1]));
      chk($sformatf("R6 status row %0d", i), 32'(status[4:0]), 32'(VEC[i][15:11]));
      chk($sformatf("R10 rdata_out row %0d", i), 32'(rdata_out), 32'(VEC[i][0]));
    end

    // Fixed mode: hold is 1024 even with masks set and hold_sel=11 (R1 R2)
    @(negedge clk);
    serial_mode = 1'b0; mask_int0 = 8'hFF; hold_sel = 2'b11; fs_tick = 1'b1;
    evt_in = '0; rdata_in = 1'b0;
    hold_run("R1 R2 fixed", 8'h02, 1024);

    // Programmable mode: 512 and 4096 (R3)
    @(negedge clk);
    serial_mode = 1'b1; mask_int0 = 8'h00; hold_sel = 2'b00;
    hold_run("R3 sel00", 8'h01, 512);
    @(negedge clk); hold_sel = 2'b11;
    hold_run("R3 sel11", 8'h08, 4096);

    // Restart of the hold on reassertion (R2)
    @(negedge clk); hold_sel = 2'b00; evt_in = 8'h02;
    @(negedge clk); evt_in = 8'h00;
    repeat (300) @(posedge clk);
    hold_run("R2 restart", 8'h02, 512);

    // Masked event: no int0, status still reports it (R5)
    @(negedge clk); mask_int0 = 8'h02; evt_in = 8'h02;
    #1;
    chk("R5 masked int0", 32'(int0), 32'd0);
    chk("R5 masked status bit", 32'(status[1]), 32'd1);
    @(negedge clk); evt_in = 8'h00; mask_int0 = 8'hFF; mask_int1 = 8'h00;

    // Sticky bits and read clear (R7 R4)
    @(negedge clk); evt_in = 8'h20;
    @(negedge clk); evt_in = 8'h00;
    #1 chk("R7 sticky set", 32'(status[5]), 32'd1);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 sticky kept", 32'(status[5]), 32'd1);
    chk("R4 int1 from sticky", 32'(int1), 32'd1);
    @(negedge clk); stat_rd = 1'b1;
    #1 chk("R7 visible during read", 32'(status[5]), 32'd1);
    @(negedge clk); stat_rd = 1'b0;
    #1;
    chk("R7 cleared after read", 32'(status[5]), 32'd0);
    chk("R4 int1 drops with source", 32'(int1), 32'd0);

    // Event during read wins (R8)
    @(negedge clk); evt_in = 8'h40; stat_rd = 1'b1;
    @(negedge clk); evt_in = 8'h00; stat_rd = 1'b0;
    #1 chk("R8 set beats read", 32'(status[6]), 32'd1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    #1 chk("R7 second read clears", 32'(status[6]), 32'd0);

    // Sample gating (R9 R10 R11)
    @(negedge clk); fs_tick = 1'b1; sample_in = 24'h123456; evt_in = 8'h00;
    @(negedge clk); #1 chk("R9 pass", 32'(sample_out), 32'h123456);
    sample_in = 24'hABCDEF; evt_in = 8'h02;
    @(negedge clk); #1 chk("R9 repeat on parity", 32'(sample_out), 32'h123456);
    fs_tick = 1'b0; evt_in = 8'h00; sample_in = 24'h111111;
    @(negedge clk); #1 chk("R9 no tick holds", 32'(sample_out), 32'h123456);
    fs_tick = 1'b1; evt_in = 8'h01; rdata_in = 1'b1;
    #1 chk("R10 rdata forced low", 32'(rdata_out), 32'd0);
    @(negedge clk); #1;
    chk("R9 zero on unlock", 32'(sample_out), 32'd0);
    chk("R11 meta_clr pulse", 32'(meta_clr), 32'd1);
    @(negedge clk); #1 chk("R11 meta_clr one cycle", 32'(meta_clr), 32'd0);
    evt_in = 8'h00;
    #1 chk("R10 rdata passes", 32'(rdata_out), 32'd1);
    @(negedge clk); #1 chk("R9 pass after relock", 32'(sample_out), 32'h111111);

    finish_run();
  end
endmodule